// File: doc/BRIEF.md
# Half-Bridge Cross-Conduction Interlock

This block sits between the command logic of a multi-leg half-bridge driver and the gate drivers of its power switches. For every leg it takes a two-bit request, one bit asking for the upper switch and one for the lower switch. It produces one enable for each gate, and it guarantees that the two switches of a leg are never on together.

A leg that is fully idle can turn on either switch at the next clock edge. When a conducting switch is released, the leg enters a hold-off interval. The opposite switch stays off for a programmable number of clock cycles, so the released device has time to stop conducting before the other one starts. If the request goes back to the side that was just released, that side is re-enabled at once. A request for both sides counts as a request for neither.

A per-leg force-off input and a global enable clear the gate enables in the same cycle. They also restart the hold-off interval, which only counts while the leg is not blocked. Each leg reports a busy flag while its hold-off interval is running.

Top module: `hbi_interlock`

## Requirements
- R1: During and directly after a synchronous reset, every gate enable and every busy flag is low.
- R2: In no cycle are the upper and lower gate enables of the same leg both high.
- R3: A leg that is idle (both gates low, busy low) enables the requested side at the next clock edge. Request encoding is cmd_hi=1,cmd_lo=0 for upper, 0,1 for lower, 0,0 for none.
- R4: On a hand-over from one side to the other, the newly requested side turns on only after max(D,1) consecutive cycles with both gates low, where D is `holdoff_cycles`. With the request held steady it turns on exactly after that many cycles. busy is high throughout those cycles.
- R5: If the request returns to the side that was last on while busy is high, that side is enabled again at the next edge.
- R6: cmd_hi=1 together with cmd_lo=1 is illegal. At the next edge both gates of that leg are low, and it is otherwise handled like a request for neither side.
- R7: Releasing a side with no new request gives both gates low at the next edge and busy high for max(D,1) cycles. After that the leg is idle and R3 applies.
- R8: force_off of a leg drives both of its gates low in the same cycle, with no clock edge needed. While it is high the hold-off count of that leg stays at zero, so a pending hand-over is cancelled and restarts from the full interval after release.
- R9: en low acts like force_off on every leg at once.
- R10: Legs are independent. Requests, force and hold-off on one leg never change the outputs of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Global enable; low blocks all legs |
| force_off | input | N_LEGS | Per-leg immediate switch-off from fault logic |
| cmd_hi | input | N_LEGS | Per-leg request for the upper switch |
| cmd_lo | input | N_LEGS | Per-leg request for the lower switch |
| holdoff_cycles | input | CNT_W | Hold-off interval in clock cycles, shared by all legs |
| gate_hi | output | N_LEGS | Upper switch enable per leg |
| gate_lo | output | N_LEGS | Lower switch enable per leg |
| busy | output | N_LEGS | High while a leg's hold-off interval runs |

## Verification
The hold-off counter can expire in the same cycle as a force, an illegal request or a return request. The bench builds those collisions on purpose. A force is applied while the interval is pending, then released, and the bench checks that the full interval runs again and does not resume from where it stopped. A request that flips back during the interval is checked for immediate re-enable with no off cycle added. An illegal request held through expiry must leave the leg idle rather than on. Each case is judged against the cycle counts worked out from the requirements, and one leg is held static while the other moves to show they stay independent.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

    typedef enum logic [2:0] {
        LEG_IDLE    = 3'd0,
        LEG_HI      = 3'd1,
        LEG_LO      = 3'd2,
        LEG_COOL_HI = 3'd3,
        LEG_COOL_LO = 3'd4
    } leg_state_e;

    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_HI   = 2'd1,
        REQ_LO   = 2'd2,
        REQ_BAD  = 2'd3
    } leg_req_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } leg_cmd_t;

    function automatic leg_req_e decode_req(leg_cmd_t c);
        leg_req_e r;
        case ({c.hi, c.lo})
            2'b10:   r = REQ_HI;
            2'b01:   r = REQ_LO;
            2'b11:   r = REQ_BAD;
            default: r = REQ_NONE;
        endcase
        return r;
    endfunction

    function automatic logic is_cooling(leg_state_e s);
        return (s == LEG_COOL_HI) || (s == LEG_COOL_LO);
    endfunction

endpackage

// File: rtl/hbi_holdoff_timer.sv
module hbi_holdoff_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold_clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || hold_clr) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // count + 1 reaches the limit: this edge completes max(limit,1) cycles
    assign expired = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit};

endmodule

// File: rtl/hbi_leg_ctrl.sv
module hbi_leg_ctrl
    import hbi_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             blocked,
    input  leg_cmd_t         cmd,
    input  logic [CNT_W-1:0] limit,
    output logic             gate_hi,
    output logic             gate_lo,
    output logic             busy
);
    leg_state_e state_q, state_d;
    leg_req_e   req;
    logic       cooling;
    logic       expired;

    assign req     = decode_req(cmd);
    assign cooling = is_cooling(state_q);

    hbi_holdoff_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .hold_clr (!cooling || blocked),
        .tick     (cooling && !blocked),
        .limit    (limit),
        .expired  (expired)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LEG_IDLE: begin
                if (!blocked) begin
                    if (req == REQ_HI)      state_d = LEG_HI;
                    else if (req == REQ_LO) state_d = LEG_LO;
                end
            end
            LEG_HI: begin
                if (blocked || req != REQ_HI) state_d = LEG_COOL_HI;
            end
            LEG_LO: begin
                if (blocked || req != REQ_LO) state_d = LEG_COOL_LO;
            end
            LEG_COOL_HI: begin
                if (!blocked) begin
                    if (req == REQ_HI)      state_d = LEG_HI;
                    else if (expired)       state_d = (req == REQ_LO) ? LEG_LO : LEG_IDLE;
                end
            end
            LEG_COOL_LO: begin
                if (!blocked) begin
                    if (req == REQ_LO)      state_d = LEG_LO;
                    else if (expired)       state_d = (req == REQ_HI) ? LEG_HI : LEG_IDLE;
                end
            end
            default: state_d = LEG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= LEG_IDLE;
        else     state_q <= state_d;
    end

    assign gate_hi = (state_q == LEG_HI) && !blocked;
    assign gate_lo = (state_q == LEG_LO) && !blocked;
    assign busy    = cooling;

endmodule

// File: rtl/hbi_interlock.sv
module hbi_interlock
    import hbi_pkg::*;
#(
    parameter int N_LEGS = 2,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [N_LEGS-1:0] force_off,
    input  logic [N_LEGS-1:0] cmd_hi,
    input  logic [N_LEGS-1:0] cmd_lo,
    input  logic [CNT_W-1:0]  holdoff_cycles,
    output logic [N_LEGS-1:0] gate_hi,
    output logic [N_LEGS-1:0] gate_lo,
    output logic [N_LEGS-1:0] busy
);
    for (genvar g = 0; g < N_LEGS; g++) begin : g_leg
        leg_cmd_t leg_cmd;
        assign leg_cmd.hi = cmd_hi[g];
        assign leg_cmd.lo = cmd_lo[g];

        hbi_leg_ctrl #(.CNT_W(CNT_W)) u_leg (
            .clk     (clk),
            .rst     (rst),
            .blocked (force_off[g] || !en),
            .cmd     (leg_cmd),
            .limit   (holdoff_cycles),
            .gate_hi (gate_hi[g]),
            .gate_lo (gate_lo[g]),
            .busy    (busy[g])
        );
    end

endmodule

// File: rtl/hbi_interlock_chk.sv
module hbi_interlock_chk #(
    parameter int N_LEGS = 2,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic [N_LEGS-1:0] force_off,
    input logic [N_LEGS-1:0] cmd_hi,
    input logic [N_LEGS-1:0] cmd_lo,
    input logic [CNT_W-1:0]  holdoff_cycles,
    input logic [N_LEGS-1:0] gate_hi,
    input logic [N_LEGS-1:0] gate_lo,
    input logic [N_LEGS-1:0] busy
);
    localparam logic [CNT_W:0] OFF_MAX = {(CNT_W+1){1'b1}};

    logic [CNT_W-1:0] prev_limit;
    always_ff @(posedge clk) begin
        if (rst) prev_limit <= '0;
        else     prev_limit <= holdoff_cycles;
    end

    for (genvar i = 0; i < N_LEGS; i++) begin : g_chk
        logic           seen_q, last_hi_q, prev_hi_q, prev_lo_q;
        logic [CNT_W:0] off_q;
        logic [CNT_W:0] need;

        assign need = (prev_limit == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, prev_limit};

        always_ff @(posedge clk) begin
            if (rst) begin
                seen_q    <= 1'b0;
                last_hi_q <= 1'b0;
                prev_hi_q <= 1'b0;
                prev_lo_q <= 1'b0;
                off_q     <= '0;
            end else begin
                prev_hi_q <= gate_hi[i];
                prev_lo_q <= gate_lo[i];
                if (gate_hi[i] || gate_lo[i]) begin
                    seen_q    <= 1'b1;
                    last_hi_q <= gate_hi[i];
                    off_q     <= '0;
                end else if (off_q != OFF_MAX) begin
                    off_q <= off_q + 1'b1;
                end
            end
        end

        // R2
        a_r2_never_both: assert property (@(posedge clk) disable iff (rst)
            !(gate_hi[i] && gate_lo[i]));

        // R4: hand-over to the lower side waits for the hold-off interval
        a_r4_holdoff_to_lo: assert property (@(posedge clk) disable iff (rst)
            (gate_lo[i] && !prev_lo_q && seen_q && last_hi_q) |-> (off_q >= need));

        // R4: hand-over to the upper side waits for the hold-off interval
        a_r4_holdoff_to_hi: assert property (@(posedge clk) disable iff (rst)
            (gate_hi[i] && !prev_hi_q && seen_q && !last_hi_q) |-> (off_q >= need));

        // R8
        a_r8_force_clears: assert property (@(posedge clk) disable iff (rst)
            force_off[i] |-> (!gate_hi[i] && !gate_lo[i]));

        // R9
        a_r9_enable_low: assert property (@(posedge clk) disable iff (rst)
            !en |-> (!gate_hi[i] && !gate_lo[i]));

        // R6
        a_r6_illegal_off: assert property (@(posedge clk) disable iff (rst)
            (cmd_hi[i] && cmd_lo[i]) |=> (!gate_hi[i] && !gate_lo[i]));

        // R3
        a_r3_idle_start: assert property (@(posedge clk) disable iff (rst)
            (!busy[i] && !gate_hi[i] && !gate_lo[i] && cmd_hi[i] && !cmd_lo[i]
             && en && !force_off[i]) |=> (gate_hi[i] || force_off[i] || !en));
    end

endmodule

bind hbi_interlock hbi_interlock_chk #(.N_LEGS(N_LEGS), .CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .en             (en),
    .force_off      (force_off),
    .cmd_hi         (cmd_hi),
    .cmd_lo         (cmd_lo),
    .holdoff_cycles (holdoff_cycles),
    .gate_hi        (gate_hi),
    .gate_lo        (gate_lo),
    .busy           (busy)
);

// File: tb/sim_hbi_interlock.sv
`timescale 1ns/1ps
module sim_hbi_interlock;
    localparam int N  = 2;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b1;
    logic [N-1:0]  force_off = '0;
    logic [N-1:0]  cmd_hi = '0;
    logic [N-1:0]  cmd_lo = '0;
    logic [CW-1:0] holdoff_cycles = 16'd3;
    logic [N-1:0]  gate_hi, gate_lo, busy;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    hbi_interlock #(.N_LEGS(N), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .en(en), .force_off(force_off),
        .cmd_hi(cmd_hi), .cmd_lo(cmd_lo), .holdoff_cycles(holdoff_cycles),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .busy(busy)
    );

    // fields: [5] cmd_hi, [4] cmd_lo, [3] force, [2] exp gate_hi, [1] exp gate_lo, [0] exp busy (leg 0, hold-off 3)
    localparam int NV = 24;
    localparam logic [5:0] VEC [NV] = '{
        6'b10_0_100, 6'b10_0_100, 6'b01_0_001, 6'b01_0_001, 6'b01_0_001, 6'b01_0_010,
        6'b10_0_001, 6'b10_0_001, 6'b01_0_010, 6'b11_0_001, 6'b11_0_001, 6'b11_0_001,
        6'b11_0_000, 6'b01_0_010, 6'b00_0_001, 6'b00_0_001, 6'b00_0_001, 6'b00_0_000,
        6'b10_0_100, 6'b10_1_001, 6'b01_1_001, 6'b01_0_001, 6'b01_0_001, 6'b01_0_010
    };

    task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [5:0] outs();
        return {gate_hi[1], gate_lo[1], busy[1], gate_hi[0], gate_lo[0], busy[0]};
    endfunction

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) step();
        chk("R1 reset state", outs(), 6'b000_000);
        rst = 1'b0;

        // vector table on leg 0, leg 1 held idle
        for (int v = 0; v < NV; v++) begin
            cmd_hi[0]    = VEC[v][5];
            cmd_lo[0]    = VEC[v][4];
            force_off[0] = VEC[v][3];
            step();
            chk($sformatf("R2-R8 table vector %0d", v), {3'b000, outs()[2:0]},
                {3'b000, VEC[v][2:0]});
            chk("R10 idle leg untouched", {outs()[5:3], 3'b000}, 6'b000_000);
        end

        // R9: enable low clears gates without an edge
        en = 1'b0;
        #1;
        chk("R9 enable low immediate", outs(), 6'b000_000);
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R9 enable low holds off", outs(), 6'b000_001);
        end
        en = 1'b1;
        step();
        chk("R5 return to last side", outs(), 6'b000_010);

        // R10: second leg moves while first stays on
        cmd_hi[1] = 1'b1;
        step();
        chk("R10 legs independent", outs(), 6'b100_010);

        // R4: long hold-off on leg 0
        holdoff_cycles = 16'd20;
        cmd_hi[0] = 1'b1;
        cmd_lo[0] = 1'b0;
        for (int k = 1; k <= 20; k++) begin
            step();
            chk("R4 long hold-off pending", outs(), 6'b100_001);
        end
        step();
        chk("R4 long hold-off done", outs(), 6'b100_100);

        // R4: zero setting still gives one off cycle
        holdoff_cycles = 16'd0;
        cmd_hi[1] = 1'b0;
        cmd_lo[1] = 1'b1;
        step();
        chk("R4 zero hold-off off cycle", outs(), 6'b001_100);
        step();
        chk("R4 zero hold-off hand-over", outs(), 6'b010_100);

        // R7 then R3: release to idle, then immediate start
        holdoff_cycles = 16'd2;
        cmd_lo[1] = 1'b0;
        step();
        chk("R7 release busy", outs(), 6'b001_100);
        step();
        chk("R7 release busy 2", outs(), 6'b001_100);
        step();
        chk("R7 back to idle", outs(), 6'b000_100);
        cmd_hi[1] = 1'b1;
        step();
        chk("R3 start from idle", outs(), 6'b100_100);

        // R8: force on leg 1 acts without an edge
        force_off[1] = 1'b1;
        #1;
        chk("R8 force immediate", outs(), 6'b000_100);
        force_off[1] = 1'b0;

        // R1: reset in the middle of operation
        rst = 1'b1;
        step();
        chk("R1 reset mid-run", outs(), 6'b000_000);
        rst = 1'b0;
        cmd_hi = '0;
        cmd_lo = '0;
        step();
        chk("R1 idle after reset", outs(), 6'b000_000);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule